// File: doc/BRIEF.md
# CAN Controller Freeze Sequencer

This block sequences a CAN controller into and out of a debug freeze state. A freeze is requested when the configuration enable bit is set and either the software halt bit or the system-level freeze line is high. The sequencer does not stop the controller at once. It first waits for a safe point on the bus: intermission, bus idle, error-passive or bus-off. It then waits until the protocol engine reports that its internal activity has drained. Only after both conditions does it acknowledge the freeze.

While frozen, the block disables the bit-rate prescaler and halts frame handling. It holds the transmit pin recessive and presents a constant recessive level to the core in place of the receive pin. It raises the not-ready and freeze-acknowledge status bits, and it lets CPU writes through to the error counters. When the request goes away, the acknowledge drops at once. Not-ready stays high until the controller has seen eleven consecutive recessive bits on the bus, which means it has synchronised again. If the request is withdrawn before the freeze is reached, the sequencer goes straight back to normal operation and never acknowledges.

Top module: `can_frz_seq`

## Requirements
- R1: A freeze request exists only when `frz_en` is 1 and at least one of `sw_halt` or `sys_freeze` is 1. With no request, `frz_ack` stays 0.
- R2: After a request, the sequencer does not leave the bus-wait phase until at least one of `bus_intermission`, `bus_idle`, `err_passive` or `bus_off` is 1. Any one of the four is enough.
- R3: Once a safe bus point has been seen, `frz_ack` stays 0 while `core_busy` is 1. It rises on the clock edge that samples `core_busy` as 0. From a steady request with a safe point and an idle core, `frz_ack` is 1 in the third cycle after the request appears.
- R4: While frozen, `presc_dis` and `proto_halt` are both 1. Outside the frozen state both are 0.
- R5: While frozen, `tx_pin` is 1 (recessive) whatever the value of `tx_core`, and `rx_core` is 1 whatever the value of `rx_pin`. Outside the frozen state, `tx_pin` follows `tx_core` and `rx_core` follows `rx_pin`.
- R6: `not_rdy` and `frz_ack` both become 1 on the same clock edge when the freeze is entered.
- R7: `ec_wr_en` follows `cpu_ec_wr` only while `frz_ack` is 1. At all other times a CPU error-counter write is ignored and `ec_wr_en` is 0.
- R8: When the request goes away while frozen, `frz_ack` clears on the next edge. `not_rdy` stays 1 until eleven `bit_tick` strobes have sampled `rx_pin` as 1 (recessive) with no dominant (0) sample between them. A dominant sample restarts the count. `not_rdy` clears one cycle after the edge that takes the eleventh recessive sample.
- R9: If the request is withdrawn during the bus-wait or drain-wait phase, the sequencer returns to normal operation with `frz_ack` and `not_rdy` both 0. A later safe point or idle core does not then freeze it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frz_en | input | 1 | Freeze enable from the configuration register |
| sw_halt | input | 1 | Software halt request |
| sys_freeze | input | 1 | System-level freeze line |
| bus_intermission | input | 1 | Bus is in intermission |
| bus_idle | input | 1 | Bus is idle |
| err_passive | input | 1 | Node is error-passive |
| bus_off | input | 1 | Node is bus-off |
| core_busy | input | 1 | Protocol engine still has internal activity |
| bit_tick | input | 1 | One-cycle strobe at each bus bit sample point |
| rx_pin | input | 1 | Receive pin level (1 = recessive) |
| tx_core | input | 1 | Transmit level from the protocol engine |
| cpu_ec_wr | input | 1 | CPU write strobe for the error counters |
| tx_pin | output | 1 | Transmit pin level, held recessive while frozen |
| rx_core | output | 1 | Receive level passed to the protocol engine |
| presc_dis | output | 1 | Bit-rate prescaler disable |
| proto_halt | output | 1 | Stops frame transmission and reception |
| not_rdy | output | 1 | Not-ready status bit |
| frz_ack | output | 1 | Freeze-acknowledge status bit |
| ec_wr_en | output | 1 | Gated error-counter write enable |

## Verification
The hardest situation to reach from the ports is the resynchronisation window after a release. There, `not_rdy` must stay set through exactly ten recessive samples and fall after the eleventh, and a dominant sample anywhere in the run must restart the count. The bench reaches it by freezing, dropping the request, and then driving individual `bit_tick` strobes with chosen `rx_pin` levels, including a dominant bit after seven recessive ones. It checks `not_rdy` after every strobe. Withdrawal during the two wait phases is reached by holding back either the safe bus point or the idle core while the request is up.

// File: rtl/can_frz_pkg.sv
// Package: shared state encoding and defaults for the CAN freeze sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package can_frz_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_WAIT_BUS   = 3'd1,
        ST_WAIT_DRAIN = 3'd2,
        ST_FROZEN     = 3'd3,
        ST_RESYNC     = 3'd4
    } frz_state_e;

    localparam int unsigned RESYNC_BITS_DEF = 11;
    localparam int unsigned NUM_SRC_DEF     = 2;
    localparam int unsigned NUM_SAFE_DEF    = 4;

endpackage

// File: rtl/frz_cond.sv
// Module: frz_cond
// Combines the freeze request sources with the enable, and combines the
// safe-bus-point indications into one flag.
// Assumes: all inputs are synchronous to clk; purely combinational.
module frz_cond #(
    parameter int unsigned NUM_SRC  = 2,
    parameter int unsigned NUM_SAFE = 4
) (
    input  logic                enable,
    input  logic [NUM_SRC-1:0]  src,
    input  logic [NUM_SAFE-1:0] safe_vec,
    output logic                req,
    output logic                safe
);

    logic [NUM_SRC-1:0]  src_or;
    logic [NUM_SAFE-1:0] safe_or;

    // OR-reduce the request sources one stage per source
    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_src
            if (gi == 0) begin : g_first
                assign src_or[gi] = src[gi];
            end else begin : g_rest
                assign src_or[gi] = src_or[gi-1] | src[gi];
            end
        end
        for (gi = 0; gi < NUM_SAFE; gi++) begin : g_safe
            if (gi == 0) begin : g_first
                assign safe_or[gi] = safe_vec[gi];
            end else begin : g_rest
                assign safe_or[gi] = safe_or[gi-1] | safe_vec[gi];
            end
        end
    endgenerate

    // The request is gated by the enable; any safe indication counts
    always_comb begin
        req  = enable & src_or[NUM_SRC-1];
        safe = safe_or[NUM_SAFE-1];
    end

endmodule

// File: rtl/frz_resync_cnt.sv
// Module: frz_resync_cnt
// Counts consecutive recessive bit samples while the sequencer is resyncing.
// The count saturates at RESYNC_BITS and flags done there.
// Assumes: bit_tick is a one-cycle strobe; rx_bit = 1 means recessive.
module frz_resync_cnt #(
    parameter int unsigned RESYNC_BITS = 11,
    localparam int unsigned CW = $clog2(RESYNC_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bit_tick,
    input  logic rx_bit,
    output logic done
);

    localparam logic [CW-1:0] LIMIT = CW'(RESYNC_BITS);

    logic [CW-1:0] cnt_q;

    // Count recessive samples; a dominant sample or leaving resync clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (bit_tick) begin
            if (!rx_bit) begin
                cnt_q <= '0;
            end else if (cnt_q != LIMIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Done once the full run of recessive bits has been seen
    always_comb done = (cnt_q == LIMIT);

    AST_CNT_NEEDS_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > $past(cnt_q)) |-> $past(bit_tick && rx_bit)) else $error("count rose without recessive sample"); // R8
    AST_DOMINANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bit_tick && !rx_bit) |=> (cnt_q == '0)) else $error("dominant bit did not clear count"); // R8

endmodule

// File: rtl/frz_fsm.sv
// Module: frz_fsm
// Phase sequencer: run -> wait bus -> wait drain -> frozen -> resync -> run.
// A withdrawn request aborts either wait phase back to run.
// Assumes: req and safe are combinational and synchronous to clk.
module frz_fsm
    import can_frz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic safe,
    input  logic busy,
    input  logic resync_done,
    output logic frozen,
    output logic resync,
    output logic ack,
    output logic not_rdy
);

    frz_state_e state_q, state_d;

    // Next-phase selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:        if (req) state_d = ST_WAIT_BUS;
            ST_WAIT_BUS:   if (!req) state_d = ST_RUN;
                           else if (safe) state_d = ST_WAIT_DRAIN;
            ST_WAIT_DRAIN: if (!req) state_d = ST_RUN;
                           else if (!busy) state_d = ST_FROZEN;
            ST_FROZEN:     if (!req) state_d = ST_RESYNC;
            ST_RESYNC:     if (req) state_d = ST_WAIT_BUS;
                           else if (resync_done) state_d = ST_RUN;
            default:       state_d = ST_RUN;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Status decode straight from the phase register
    always_comb begin
        frozen  = (state_q == ST_FROZEN);
        resync  = (state_q == ST_RESYNC);
        ack     = frozen;
        not_rdy = frozen | resync;
    end

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req)) else $error("ack without request"); // R1
    AST_ACK_NEEDS_IDLE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(!busy)) else $error("ack while core busy"); // R3
    AST_DRAIN_AFTER_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_BUS && req && !safe) |=> (state_q == ST_WAIT_BUS)) else $error("left bus wait early"); // R2
    AST_ENTRY_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $rose(not_rdy)) else $error("entry did not set both"); // R6
    AST_RELEASE_KEEPS_NOTRDY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> not_rdy) else $error("not_rdy fell with ack"); // R8
    AST_ABORT_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WAIT_BUS || state_q == ST_WAIT_DRAIN) && !req) |=> (state_q == ST_RUN)) else $error("abort missed"); // R9

endmodule

// File: rtl/can_frz_seq.sv
// Module: can_frz_seq (top)
// Freeze sequencer for a CAN controller: gathers the request, steps through
// the safe-point and drain waits, forces the pins while frozen, gates CPU
// error-counter writes, and counts recessive bits on release.
// Assumes: bit_tick comes from the bit timing logic; 1 on a pin = recessive.
module can_frz_seq
    import can_frz_pkg::*;
#(
    parameter int unsigned RESYNC_BITS = RESYNC_BITS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frz_en,
    input  logic sw_halt,
    input  logic sys_freeze,
    input  logic bus_intermission,
    input  logic bus_idle,
    input  logic err_passive,
    input  logic bus_off,
    input  logic core_busy,
    input  logic bit_tick,
    input  logic rx_pin,
    input  logic tx_core,
    input  logic cpu_ec_wr,
    output logic tx_pin,
    output logic rx_core,
    output logic presc_dis,
    output logic proto_halt,
    output logic not_rdy,
    output logic frz_ack,
    output logic ec_wr_en
);

    logic req, safe, frozen, resync, resync_done;

    frz_cond #(
        .NUM_SRC (NUM_SRC_DEF),
        .NUM_SAFE(NUM_SAFE_DEF)
    ) u_cond (
        .enable  (frz_en),
        .src     ({sys_freeze, sw_halt}),
        .safe_vec({bus_off, err_passive, bus_idle, bus_intermission}),
        .req     (req),
        .safe    (safe)
    );

    frz_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .safe       (safe),
        .busy       (core_busy),
        .resync_done(resync_done),
        .frozen     (frozen),
        .resync     (resync),
        .ack        (frz_ack),
        .not_rdy    (not_rdy)
    );

    frz_resync_cnt #(
        .RESYNC_BITS(RESYNC_BITS)
    ) u_resync (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (resync),
        .bit_tick(bit_tick),
        .rx_bit  (rx_pin),
        .done    (resync_done)
    );

    // Pin overrides, halt controls and the CPU write gate
    always_comb begin
        tx_pin     = frozen ? 1'b1 : tx_core;
        rx_core    = frozen ? 1'b1 : rx_pin;
        presc_dis  = frozen;
        proto_halt = frozen;
        ec_wr_en   = cpu_ec_wr & frz_ack;
    end

    AST_PINS_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        frz_ack |-> (tx_pin && rx_core)) else $error("pins not recessive"); // R5
    AST_PRESC_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        presc_dis |-> (frz_ack && proto_halt)) else $error("prescaler off outside freeze"); // R4
    AST_EC_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ec_wr_en |-> (frz_ack && cpu_ec_wr)) else $error("ungated ec write"); // R7

endmodule

// File: tb/can_frz_seq_tb.sv
// Bench for can_frz_seq: sweeps request sources, safe points, pin levels and
// the resync run; expected values are derived from the requirements.
module can_frz_seq_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frz_en = 0, sw_halt = 0, sys_freeze = 0;
    logic bus_intermission = 0, bus_idle = 0, err_passive = 0, bus_off = 0;
    logic core_busy = 0, bit_tick = 0, rx_pin = 1, tx_core = 1, cpu_ec_wr = 0;
    logic tx_pin, rx_core, presc_dis, proto_halt, not_rdy, frz_ack, ec_wr_en;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    can_frz_seq u_dut (
        .clk(clk), .rst_n(rst_n), .frz_en(frz_en), .sw_halt(sw_halt),
        .sys_freeze(sys_freeze), .bus_intermission(bus_intermission),
        .bus_idle(bus_idle), .err_passive(err_passive), .bus_off(bus_off),
        .core_busy(core_busy), .bit_tick(bit_tick), .rx_pin(rx_pin),
        .tx_core(tx_core), .cpu_ec_wr(cpu_ec_wr), .tx_pin(tx_pin),
        .rx_core(rx_core), .presc_dis(presc_dis), .proto_halt(proto_halt),
        .not_rdy(not_rdy), .frz_ack(frz_ack), .ec_wr_en(ec_wr_en)
    );

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Advance one clock and settle 2 ns past the edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic tick_bit(input logic lvl);
        rx_pin = lvl;
        bit_tick = 1'b1;
        step(1);
        bit_tick = 1'b0;
    endtask

    // Drop all requests and walk the resync run back to normal
    task automatic release_all();
        frz_en = 0; sw_halt = 0; sys_freeze = 0;
        step(1);
        for (int i = 0; i < 11; i++) tick_bit(1'b1);
        step(2);
    endtask

    task automatic clear_safe();
        bus_intermission = 0; bus_idle = 0; err_passive = 0; bus_off = 0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // Reset state
        check("R1 reset ack", frz_ack, 0);
        check("R8 reset not_rdy", not_rdy, 0);
        check("R4 reset presc_dis", presc_dis, 0);

        // R1: sweep enable and both sources with a safe bus and idle core
        bus_idle = 1;
        for (int c = 0; c < 8; c++) begin
            frz_en = c[2]; sw_halt = c[1]; sys_freeze = c[0];
            step(3);
            check("R1 source sweep ack", frz_ack, c[2] & (c[1] | c[0]));
            release_all();
        end

        // R2: no safe point holds the wait; each safe point alone releases it
        clear_safe();
        frz_en = 1; sw_halt = 1;
        step(6);
        check("R2 no safe point", frz_ack, 0);
        release_all();
        for (int s = 0; s < 4; s++) begin
            bus_intermission = (s == 0); bus_idle = (s == 1);
            err_passive = (s == 2); bus_off = (s == 3);
            frz_en = 1; sys_freeze = 1;
            step(2);
            check("R6 not yet frozen", frz_ack, 0);
            step(1);
            check("R2 single safe point", frz_ack, 1);
            check("R6 not_rdy with ack", not_rdy, 1);
            release_all();
        end

        // R3: busy core blocks the freeze until it drains
        clear_safe(); bus_idle = 1; core_busy = 1;
        frz_en = 1; sw_halt = 1;
        step(6);
        check("R3 busy blocks", frz_ack, 0);
        core_busy = 0;
        step(1);
        check("R3 drain releases", frz_ack, 1);

        // R4 / R5 / R7 while frozen
        check("R4 presc_dis", presc_dis, 1);
        check("R4 proto_halt", proto_halt, 1);
        for (int p = 0; p < 4; p++) begin
            tx_core = p[1]; rx_pin = p[0];
            #1;
            check("R5 tx forced", tx_pin, 1);
            check("R5 rx forced", rx_core, 1);
        end
        cpu_ec_wr = 1; #1;
        check("R7 write passes frozen", ec_wr_en, 1);
        cpu_ec_wr = 0; #1;
        check("R7 no strobe", ec_wr_en, 0);

        // R8: release; ack falls, not_rdy needs 11 clean recessive samples
        frz_en = 0; sw_halt = 0;
        step(1);
        check("R8 ack cleared", frz_ack, 0);
        check("R8 not_rdy held", not_rdy, 1);
        check("R4 presc back on", presc_dis, 0);
        cpu_ec_wr = 1; #1;
        check("R7 write ignored resync", ec_wr_en, 0);
        cpu_ec_wr = 0;
        for (int i = 0; i < 7; i++) tick_bit(1'b1);
        tick_bit(1'b0);
        for (int i = 0; i < 10; i++) begin
            tick_bit(1'b1);
            step(1);
            check("R8 not_rdy during run", not_rdy, 1);
        end
        tick_bit(1'b1);
        check("R8 one cycle after 11th", not_rdy, 1);
        step(1);
        check("R8 not_rdy cleared", not_rdy, 0);

        // R5: pass-through outside the freeze
        for (int p = 0; p < 4; p++) begin
            tx_core = p[1]; rx_pin = p[0];
            #1;
            check("R5 tx passthrough", tx_pin, p[1]);
            check("R5 rx passthrough", rx_core, p[0]);
        end
        rx_pin = 1;
        cpu_ec_wr = 1; #1;
        check("R7 write ignored run", ec_wr_en, 0);
        cpu_ec_wr = 0;

        // R9: abort from bus wait, then from drain wait
        clear_safe();
        frz_en = 1; sw_halt = 1;
        step(3);
        sw_halt = 0;
        step(1);
        bus_idle = 1;
        step(4);
        check("R9 abort bus wait ack", frz_ack, 0);
        check("R9 abort bus wait not_rdy", not_rdy, 0);
        core_busy = 1; sys_freeze = 1;
        step(4);
        sys_freeze = 0;
        step(1);
        core_busy = 0;
        step(4);
        check("R9 abort drain ack", frz_ack, 0);
        check("R9 abort drain not_rdy", not_rdy, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule